// File: doc/BRIEF.md
# Timer interrupt flag register

This block keeps the two pending-interrupt flags of an 8-bit timer/counter: one for a compare match and one for overflow. The counter core sends single-cycle event pulses. The block latches each pulse into its flag bit and shows the flags to the processor through an 8-bit register. Software clears a flag by writing a one to its bit. The interrupt controller clears a flag by pulsing that flag's acknowledge line when it takes the vector.

The overflow flag has two possible sources, picked by the counter's mode. In the normal modes it is set when the count wraps around. In up/down PWM mode it is set instead when the count turns around at zero.

Each flag drives its own interrupt request. A request is the AND of the global enable, the flag's local enable and the flag itself, with no register in between. When a flag clears, its request therefore falls in the same cycle.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, both flag bits are zero and both interrupt requests are low.
- R2: A one-cycle `cmp_match_i` pulse sets the compare flag, which is read at bit 1. The flag stays set until it is cleared.
- R3: When `pwm_mode_i` is low, an `ovf_wrap_i` pulse sets the overflow flag, which is read at bit 0. A `pwm_bottom_i` pulse has no effect in this mode.
- R4: When `pwm_mode_i` is high, a `pwm_bottom_i` pulse sets the overflow flag. An `ovf_wrap_i` pulse has no effect in this mode.
- R5: A write with `sel_i` and `we_i` high clears every flag whose bit in `wdata_i` is one. It leaves every flag whose bit is zero unchanged.
- R6: A write does not change any flag unless `sel_i` and `we_i` are both high.
- R7: A one-cycle `cmp_ack_i` clears the compare flag. A one-cycle `ovf_ack_i` clears the overflow flag.
- R8: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R9: `cmp_irq_o` equals `glob_ie_i & cmp_ie_i & compare flag`. `ovf_irq_o` equals `glob_ie_i & ovf_ie_i & overflow flag`. Neither has a register delay.
- R10: Bits 7 to 2 of `rdata_o` always read as zero and ignore writes. `rdata_o` is zero while `sel_i` is low. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_match_i | input | 1 | Compare-match event pulse |
| ovf_wrap_i | input | 1 | Counter wraparound pulse |
| pwm_bottom_i | input | 1 | Direction turn at zero in PWM mode |
| pwm_mode_i | input | 1 | Up/down PWM mode is active |
| glob_ie_i | input | 1 | Global interrupt enable |
| cmp_ie_i | input | 1 | Compare interrupt enable |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cmp_ack_i | input | 1 | Compare vector taken |
| ovf_ack_i | input | 1 | Overflow vector taken |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data, ones clear flags |
| rdata_o | output | 8 | Read data |
| cmp_irq_o | output | 1 | Compare interrupt request |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench targets the overflow source switch. It drives the wrap pulse and the bottom pulse in both modes, so a design that ignored the mode would set the flag from the wrong event. It applies a set and a clear to the same flag in one cycle, where a clear-priority design would lose the event. It also writes zeros, writes with the select or strobe low, and writes ones to the reserved bits. These catch a toggle-on-write design, an unqualified strobe and reserved bits that read back as stored. Finally, it checks that the interrupt request falls on the very edge that clears the flag, which a registered request would miss by one cycle.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned FLAG_N  = 2;
  localparam int unsigned OVF_IDX = 0;
  localparam int unsigned CMP_IDX = 1;
endpackage

// File: rtl/ovf_src_sel.sv
module ovf_src_sel (
  input  logic pwm_mode_i,
  input  logic wrap_i,
  input  logic bottom_i,
  output logic evt_o
);
  always_comb evt_o = pwm_mode_i ? bottom_i : wrap_i;
endmodule

// File: rtl/flag_cell.sv
module flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority so no event is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned N = 2
) (
  input  logic         glob_ie_i,
  input  logic [N-1:0] ie_i,
  input  logic [N-1:0] flag_i,
  output logic [N-1:0] irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_gate
    assign irq_o[g] = glob_ie_i & ie_i[g] & flag_i[g];
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_flag_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_match_i,
  input  logic              ovf_wrap_i,
  input  logic              pwm_bottom_i,
  input  logic              pwm_mode_i,
  input  logic              glob_ie_i,
  input  logic              cmp_ie_i,
  input  logic              ovf_ie_i,
  input  logic              cmp_ack_i,
  input  logic              ovf_ack_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cmp_irq_o,
  output logic              ovf_irq_o
);
  localparam int unsigned RSV_W = DATA_W - FLAG_N;

  logic              ovf_evt;
  logic [FLAG_N-1:0] set_vec, ack_vec, wr_clr, clr_vec, flags, ie_vec, irq_vec;

  ovf_src_sel u_ovf_sel (
    .pwm_mode_i (pwm_mode_i),
    .wrap_i     (ovf_wrap_i),
    .bottom_i   (pwm_bottom_i),
    .evt_o      (ovf_evt)
  );

  always_comb begin
    set_vec          = '0;
    ack_vec          = '0;
    ie_vec           = '0;
    set_vec[CMP_IDX] = cmp_match_i;
    set_vec[OVF_IDX] = ovf_evt;
    ack_vec[CMP_IDX] = cmp_ack_i;
    ack_vec[OVF_IDX] = ovf_ack_i;
    ie_vec[CMP_IDX]  = cmp_ie_i;
    ie_vec[OVF_IDX]  = ovf_ie_i;
    wr_clr           = (sel_i && we_i) ? wdata_i[FLAG_N-1:0] : '0;
    clr_vec          = wr_clr | ack_vec;
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flags[g])
    );
  end

  irq_gate #(.N(FLAG_N)) u_gate (
    .glob_ie_i (glob_ie_i),
    .ie_i      (ie_vec),
    .flag_i    (flags),
    .irq_o     (irq_vec)
  );

  assign cmp_irq_o = irq_vec[CMP_IDX];
  assign ovf_irq_o = irq_vec[OVF_IDX];
  assign rdata_o   = sel_i ? {{RSV_W{1'b0}}, flags} : '0;

  // R4
  pwm_wrap_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode_i && ovf_wrap_i && !pwm_bottom_i && !flags[OVF_IDX]) |=> !flags[OVF_IDX]);
  // R9
  ack_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_ack_i && !ovf_evt) |=> !ovf_irq_o);
  // R2
  cmp_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_match_i |=> flags[CMP_IDX]);
endmodule

// File: tb/tb_tmr_irq_flags.sv
module tb_tmr_irq_flags;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic       cmp, wrap, bot, pwm, ack_c, ack_o, sel, we;
    logic [7:0] wd;
    logic [1:0] exp;
    logic [3:0] req;
  } vec_t;

  // fields: cmp wrap bot pwm ack_c ack_o sel we wdata exp{cmp,ovf} req
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,0,0,0,0,8'h00,2'b10,4'd2},  // R2 compare sets
    '{0,1,0,0,0,0,0,0,8'h00,2'b11,4'd3},  // R3 wrap sets in normal
    '{0,0,0,0,0,0,1,1,8'h00,2'b11,4'd5},  // R5 zero write keeps
    '{0,0,0,0,0,0,1,1,8'h02,2'b01,4'd5},  // R5 one clears cmp
    '{0,0,0,0,0,0,0,1,8'h01,2'b01,4'd6},  // R6 no select
    '{0,0,0,0,0,0,1,0,8'h01,2'b01,4'd6},  // R6 no strobe
    '{0,0,0,0,0,1,0,0,8'h00,2'b00,4'd7},  // R7 ovf ack
    '{0,0,1,0,0,0,0,0,8'h00,2'b00,4'd3},  // R3 bottom ignored normal
    '{0,1,0,1,0,0,0,0,8'h00,2'b00,4'd4},  // R4 wrap ignored pwm
    '{0,0,1,1,0,0,0,0,8'h00,2'b01,4'd4},  // R4 bottom sets pwm
    '{1,0,0,0,1,0,0,0,8'h00,2'b11,4'd8},  // R8 set beats ack
    '{0,0,1,1,0,0,1,1,8'h03,2'b01,4'd8},  // R8 set beats write
    '{0,0,0,0,1,1,0,0,8'h00,2'b00,4'd7},  // R7 both acks
    '{1,0,0,0,0,0,1,1,8'hFC,2'b10,4'd10}, // R10 reserved write
    '{0,0,0,0,0,0,1,1,8'hFD,2'b10,4'd10}  // R10 reserved write
  };

  logic clk = 0, rst_n = 0;
  logic cmp, wrap, bot, pwm, gie, cie, oie, ack_c, ack_o, sel, we;
  logic [7:0] wd, rd;
  logic cirq, oirq;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_irq_flags dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_match_i(cmp), .ovf_wrap_i(wrap),
    .pwm_bottom_i(bot), .pwm_mode_i(pwm), .glob_ie_i(gie), .cmp_ie_i(cie),
    .ovf_ie_i(oie), .cmp_ack_i(ack_c), .ovf_ack_i(ack_o), .sel_i(sel),
    .we_i(we), .wdata_i(wd), .rdata_o(rd), .cmp_irq_o(cirq), .ovf_irq_o(oirq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    {cmp, wrap, bot, pwm, ack_c, ack_o, we} = '0;
    sel = 0; wd = '0;
  endtask

  // read flags just after an edge
  task automatic read_flags(output logic [7:0] v);
    sel = 1; we = 0; {cmp, wrap, bot, ack_c, ack_o} = '0;
    #1 v = rd;
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(); gie = 0; cie = 0; oie = 0;
    #(CLK_P*2);
    sel = 1; #1;
    chk("R1 flags", rd, 8'h00);
    chk("R1 irq", {6'b0, cirq, oirq}, 8'h00);
    sel = 0; #1;
    chk("R10 unselected", rd, 8'h00);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cmp, wrap, bot, pwm, ack_c, ack_o, sel, we} =
        {VEC[i].cmp, VEC[i].wrap, VEC[i].bot, VEC[i].pwm,
         VEC[i].ack_c, VEC[i].ack_o, VEC[i].sel, VEC[i].we};
      wd = VEC[i].wd;
      @(posedge clk); #1;
      read_flags(v);
      chk($sformatf("R%0d vec %0d", VEC[i].req, i), v, {6'b0, VEC[i].exp});
    end

    // R9 irq gating, compare flag is set here
    @(negedge clk); idle(); gie = 1; cie = 1; oie = 1; #1;
    chk("R9 cmp irq", {6'b0, cirq, oirq}, 8'h02);
    gie = 0; #1;
    chk("R9 global off", {6'b0, cirq, oirq}, 8'h00);
    gie = 1; cie = 0; #1;
    chk("R9 local off", {6'b0, cirq, oirq}, 8'h00);
    cie = 1; sel = 1; #1;
    chk("R10 read no side effect", rd, 8'h02);
    sel = 0;
    @(negedge clk); sel = 1; we = 1; wd = 8'h02;
    @(posedge clk); #1;
    chk("R9 irq drops with flag", {6'b0, cirq, oirq}, 8'h00);

    // R9 overflow request via pwm bottom
    @(negedge clk); idle(); pwm = 1; bot = 1;
    @(posedge clk); #1;
    chk("R9 ovf irq", {6'b0, cirq, oirq}, 8'h01);

    // R1 reset mid-run
    @(negedge clk); idle(); cmp = 1;
    @(posedge clk); #1; idle();
    rst_n = 0; #1; sel = 1; #1;
    chk("R1 async reset", rd, 8'h00);
    chk("R1 irq after reset", {6'b0, cirq, oirq}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule